// File: doc/BRIEF.md
# Pulse Accumulator with Flags

This block is an 8-bit pulse accumulator that sits behind a small register bus. It can count edges on an external pulse input. It can also measure how long that input stays at its active level, by counting one step for every 64 clock cycles of gating. The pulse input is synchronised and edge-detected inside the block. A control register sets the operating mode, the active polarity and a master enable.

Two sticky flags report events: a wrap flag when the accumulator rolls from its top value back to zero, and a trigger flag on every counted edge in edge mode or on the trailing edge of the gate in gated mode. Software clears a flag by writing a one to its bit. A mask register selects which flags drive the single interrupt request. The accumulator itself has no reset, so software must load it before use. Its contents survive a reset.

Register map (2-bit address): 0 = control (bit 0 enable, bit 1 gated mode, bit 2 invert: falling edge or low-active gate; other bits read 0); 1 = accumulator; 2 = flags (bit 5 wrap, bit 4 trigger; other bits read 0); 3 = mask (bit 5 wrap enable, bit 4 trigger enable; other bits read 0). Reads are combinational from `bus_addr`. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `pulse_acc`

## Requirements
- R1: Reset clears the control, flag and mask registers to 0x00 and drops `irq`, and it leaves the accumulator value unchanged.
- R2: The accumulator at address 1 reads back the last value written to it, and the control register at address 0 reads back bits 2:0 as written.
- R3: With control = 0x01 (enabled, edge mode, non-inverted), each rising edge of `pulse_in` adds one to the accumulator and sets the trigger flag (flags bit 4). The result is visible two clock edges after the first edge that samples the new input level.
- R4: With the invert bit set (control = 0x05), only falling edges of `pulse_in` are counted.
- R5: With control = 0x03 (gated, high-active), the accumulator gains one for every 64 consecutive cycles the gate is active. The 64-cycle phase restarts whenever the gate goes inactive, and the gate's trailing edge sets the trigger flag.
- R6: An increment from 0xFF gives 0x00 and sets the wrap flag (flags bit 5). An increment to any other value leaves the wrap flag alone.
- R7: Writing a one to a flag bit at address 2 clears that flag. Writing a zero leaves it set.
- R8: A bus write to the accumulator in the same cycle as an increment stores the written value, with no increment applied.
- R9: `irq` is high while any flag is set and its mask bit (address 3, same bit position) is set. It stays high until the flag is cleared or the mask bit is removed.
- R10: While the enable bit is 0, pulse activity changes neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pulse_in | input | 1 | Asynchronous external pulse or gate input |
| irq | output | 1 | Combined interrupt request |

## Verification
`pulse_in` passes through two synchroniser flops and a history flop. A level driven before clock edge k therefore shows up in the accumulator and flags after edge k+2. The bench waits at least three edges after each input change and samples on the falling clock edge. Register writes land on the next rising edge. `bus_rdata` and `irq` are combinational from registers, so they are sampled half a cycle after that edge. Gated-mode checks hold the input for a known number of cycles: 200 active cycles give three steps and 40 give none. The margin from the 64-cycle boundaries keeps the expected count exact. For the write-priority case, the write is placed on exactly the edge that carries the increment.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int WRAP_BIT = 5;
    localparam int TRIG_BIT = 4;
    localparam int CTRL_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_ACCUM = 2'd1,
        SEL_FLAGS = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic invert;
        logic gated;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic wrap;
        logic trig;
    } flag_t;

    function automatic flag_t bits_to_flags(input logic [DATA_W-1:0] d);
        flag_t f;
        f.wrap = d[WRAP_BIT];
        f.trig = d[TRIG_BIT];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] flags_to_bits(input flag_t f);
        logic [DATA_W-1:0] d;
        d           = '0;
        d[WRAP_BIT] = f.wrap;
        d[TRIG_BIT] = f.trig;
        return d;
    endfunction

endpackage

// File: rtl/pacc_input.sv
module pacc_input #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic invert,
    output logic active,
    output logic lead,
    output logic trail
);
    logic [STAGES-1:0] chain;
    logic              active_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign active = chain[STAGES-1] ^ invert;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    assign lead  = active & ~active_q;
    assign trail = ~active & active_q;

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    logic [PRE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    assign tick = run && (phase == {PRE_W{1'b1}});

endmodule

// File: rtl/pacc_core.sv
module pacc_core
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              trig_set,
    input  flag_t             clr,
    output logic [DATA_W-1:0] accum,
    output flag_t             flags
);
    logic  wrap_now;
    flag_t flags_n;

    assign wrap_now = inc && !acc_wr && (accum == {DATA_W{1'b1}});

    always_ff @(posedge clk) begin
        if (acc_wr)   accum <= acc_wdata;
        else if (inc) accum <= accum + 1'b1;
    end

    always_comb begin
        flags_n.wrap = wrap_now | (flags.wrap & ~clr.wrap);
        flags_n.trig = trig_set | (flags.trig & ~clr.trig);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_n;
    end

endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pulse_in,
    output logic              irq
);
    ctrl_t             ctrl_q;
    flag_t             mask_q;
    flag_t             flags;
    flag_t             clr;
    logic [DATA_W-1:0] accum;
    logic              active, lead, trail, tick;
    logic              inc, trig_set;
    logic              wr_ctrl, wr_accum, wr_flags, wr_mask;
    reg_sel_e          sel;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
    assign wr_accum = bus_wr && (sel == SEL_ACCUM);
    assign wr_flags = bus_wr && (sel == SEL_FLAGS);
    assign wr_mask  = bus_wr && (sel == SEL_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_mask) mask_q <= bits_to_flags(bus_wdata);
        end
    end

    pacc_input #(.STAGES(SYNC_STAGES)) u_input (
        .clk    (clk),
        .rst    (rst),
        .din    (pulse_in),
        .invert (ctrl_q.invert),
        .active (active),
        .lead   (lead),
        .trail  (trail)
    );

    pacc_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.enable && ctrl_q.gated && active),
        .tick (tick)
    );

    always_comb begin
        inc      = 1'b0;
        trig_set = 1'b0;
        if (ctrl_q.enable) begin
            if (ctrl_q.gated) begin
                inc      = tick;
                trig_set = trail;
            end else begin
                inc      = lead;
                trig_set = lead;
            end
        end
    end

    assign clr = wr_flags ? bits_to_flags(bus_wdata) : flag_t'('0);

    pacc_core u_core (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc),
        .acc_wr    (wr_accum),
        .acc_wdata (bus_wdata),
        .trig_set  (trig_set),
        .clr       (clr),
        .accum     (accum),
        .flags     (flags)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            SEL_ACCUM: bus_rdata = accum;
            SEL_FLAGS: bus_rdata = flags_to_bits(flags);
            SEL_MASK:  bus_rdata = flags_to_bits(mask_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (flags.wrap & mask_q.wrap) | (flags.trig & mask_q.trig);

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
    import pacc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl_q,
    input flag_t             mask_q,
    input flag_t             flags,
    input logic [DATA_W-1:0] accum,
    input logic              inc,
    input logic              wr_accum,
    input logic              wr_flags,
    input logic              wr_mask,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags == '0 && mask_q == '0 && ctrl_q == '0)); // R1

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_accum |=> (accum == $past(bus_wdata))); // R8

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_accum && accum == {DATA_W{1'b1}}) |=> flags.wrap); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.wrap && !(wr_flags && bus_wdata[WRAP_BIT])) |=> flags.wrap); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !wr_flags) |=> $stable(flags)); // R10

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0)); // R9

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_flags && !wr_mask) |=> irq); // R9
endmodule

bind pulse_acc pacc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .flags     (flags),
    .accum     (accum),
    .inc       (inc),
    .wr_accum  (wr_accum),
    .wr_flags  (wr_flags),
    .wr_mask   (wr_mask),
    .bus_wdata (bus_wdata),
    .irq       (irq)
);

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pulse_in = 1'b0;
    logic       irq;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pulse_acc u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pulse_in  (pulse_in),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic v, input int hold);
        @(negedge clk);
        pulse_in = v;
        idle(hold);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d); check("R1 ctrl after reset", d, 8'h00);
        rd(2'd2, d); check("R1 flags after reset", d, 8'h00);
        rd(2'd3, d); check("R1 mask after reset", d, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'hA5);
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(2'd1, d); check("R1 accum kept over reset", d, 8'hA5);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(2'd1, 8'h3C);
        rd(2'd1, d); check("R2 accum readback", d, 8'h3C);
        wr(2'd0, 8'h06);
        rd(2'd0, d); check("R2 ctrl readback", d, 8'h06);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_rising;
        logic [7:0] d;
        pulse_in = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd10);
        wr(2'd2, 8'h30);
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, 3);
            drive(1'b0, 3);
        end
        idle(2);
        rd(2'd1, d); check("R3 five rising edges", d, 8'd15);
        rd(2'd2, d); check("R3 trigger flag", d, 8'h10);
    endtask

    task automatic t_falling;
        logic [7:0] d;
        drive(1'b1, 4);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h30);
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 3);
            drive(1'b1, 3);
        end
        idle(2);
        rd(2'd1, d); check("R4 three falling edges", d, 8'd3);
        drive(1'b0, 4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        pulse_in = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFE);
        wr(2'd2, 8'h30);
        drive(1'b1, 4); drive(1'b0, 4);
        rd(2'd1, d); check("R6 step to FF", d, 8'hFF);
        rd(2'd2, d); check("R6 no wrap flag at FF", d, 8'h10);
        drive(1'b1, 4); drive(1'b0, 4);
        rd(2'd1, d); check("R6 wrap to 00", d, 8'h00);
        rd(2'd2, d); check("R6 wrap flag set", d, 8'h30);
    endtask

    task automatic t_w1c;
        logic [7:0] d;
        wr(2'd2, 8'h00);
        rd(2'd2, d); check("R7 zero write keeps flags", d, 8'h30);
        wr(2'd2, 8'h20);
        rd(2'd2, d); check("R7 clear wrap only", d, 8'h10);
        wr(2'd2, 8'h10);
        rd(2'd2, d); check("R7 clear trigger", d, 8'h00);
    endtask

    task automatic t_irq;
        pulse_in = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd3, 8'h20);
        wr(2'd1, 8'hFF);
        drive(1'b1, 4); drive(1'b0, 4);
        check("R9 irq on masked wrap", {7'd0, irq}, 8'h01);
        idle(6);
        check("R9 irq held", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h00);
        check("R9 irq off when unmasked", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h20);
        check("R9 irq back with mask", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h20);
        check("R9 irq cleared with wrap flag", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h10);
        drive(1'b1, 4); drive(1'b0, 4);
        check("R9 irq on masked trigger", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_priority;
        logic [7:0] d;
        pulse_in = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h40);
        idle(2);
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h77;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(3);
        rd(2'd1, d); check("R8 write beats increment", d, 8'h77);
        drive(1'b0, 4);
        wr(2'd2, 8'h30);
    endtask

    task automatic t_gated;
        logic [7:0] d;
        pulse_in = 1'b0;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h30);
        drive(1'b1, 200);
        rd(2'd2, d); check("R5 no trigger while gate open", d, 8'h00);
        drive(1'b0, 4);
        rd(2'd1, d); check("R5 200 active cycles", d, 8'd3);
        rd(2'd2, d); check("R5 trailing edge trigger", d, 8'h10);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h10);
        drive(1'b1, 40); drive(1'b0, 10);
        drive(1'b1, 40); drive(1'b0, 4);
        rd(2'd1, d); check("R5 phase restarts", d, 8'd0);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h30);
    endtask

    task automatic t_disabled;
        logic [7:0] d;
        pulse_in = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h55);
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 3); drive(1'b0, 3);
        end
        rd(2'd1, d); check("R10 accum frozen", d, 8'h55);
        rd(2'd2, d); check("R10 flags frozen", d, 8'h00);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset;
        t_regs;
        t_rising;
        t_falling;
        t_overflow;
        t_w1c;
        t_irq;
        t_priority;
        t_gated;
        t_disabled;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule